// File: doc/BRIEF.md
# Bus Width Test Pattern Responder

Card-side logic that answers a bus width test issued by a host. Once armed for receive, the block waits for a low start bit on data line 0, then takes the next two bit times from every data line. The host drives alternating values there: 1,0 on even lines and 0,1 on odd lines. Anything the host sends after those two bits is neither sampled nor checked, including its CRC.

When the block is then told to send, it drives every line with a frame of its own. The frame is a low start bit, an eight-bit pattern, a CRC16 over that pattern, and a high end bit. On a line that takes part in the test, the pattern is the inverse of the two bits captured on that same line, followed by six zeros. A line that is disconnected or shorted therefore returns a wrong value, and the host can see which lines work. In 4-line mode the upper half of the lines is never sampled, and those lines return an all-zero pattern. The mode is taken when receive is armed. A single-cycle pulse marks the end of the reply, and the output enables drop in that same cycle.

Top module: `bus_test_responder`

## Requirements
- R1: After reset, `dat_oe_o` is all zeros and `rx_done_o` and `tx_done_o` are low. The captured bits reset to 0 and the mode to 8-line, so a reply sent before any receive carries pattern 8'hC0 on every line.
- R2: After `rx_start_i`, the first cycle with `dat_i[0]` low is the start bit, and only line 0 is used to detect it. The two following cycles are sampled on every line as the first and second bit. `rx_done_o` is high for exactly the one cycle after the second bit is sampled. Later host bits have no effect on the reply.
- R3: After `tx_start_i` is sampled while idle, `dat_oe_o` is all ones for 26 cycles starting at the next cycle. Each line carries, in order: a 0, eight pattern bits MSB first, sixteen CRC bits MSB first, and a 1.
- R4: On a participating line i, the pattern is {~first[i], ~second[i], 6'b000000}, built only from the bits captured on line i.
- R5: With `mode8_i` = 0 at `rx_start_i`, lines 4 to 7 are not used and their pattern is 8'h00. With `mode8_i` = 1, all eight lines participate.
- R6: Each line's CRC uses polynomial 16'h1021 (x^16+x^12+x^5+1), a zero seed, and the eight pattern bits as input, MSB first.
- R7: `tx_done_o` is high for exactly one cycle, in the cycle right after the end bit. `dat_oe_o` is zero in that cycle.
- R8: `rx_start_i` and `tx_start_i` are ignored while a receive or a reply is in progress. If both are high while idle, receive wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode8_i | input | 1 | 1 = 8-line test, 0 = 4-line test; taken at rx_start_i |
| rx_start_i | input | 1 | Arm capture of the host pattern |
| tx_start_i | input | 1 | Send the reply frame |
| dat_i | input | NUM_LINES | Data lines as seen by the card |
| dat_o | output | NUM_LINES | Data line drive values |
| dat_oe_o | output | NUM_LINES | Data line output enables |
| rx_done_o | output | 1 | Pulse: host pattern captured |
| tx_done_o | output | 1 | Pulse: reply frame finished |

## Verification
The assertions assume that `tx_start_i` is never pulsed in the same cycle as the last bit of a reply. They also assume that the reset stays asserted across the first clock edge, so that the outputs begin from their reset values. The bench drives inputs only on falling edges and raises each trigger for a single cycle. It applies a trigger again only after the matching done pulse has been seen, except in the one scenario that deliberately pulses both triggers in the middle of a frame. In that scenario the pulses fall at frame bit 10, well away from the end bit.

// File: rtl/bus_test_pkg.sv
package bus_test_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_WAIT,
    ST_RX_B0,
    ST_RX_B1,
    ST_TX
  } state_e;

  typedef enum logic [1:0] {
    PH_START,
    PH_DATA,
    PH_CRC,
    PH_END
  } phase_e;
endpackage

// File: rtl/bus_test_capture.sv
module bus_test_capture #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned PAT_BITS  = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_LINES-1:0]                dat_i,
  input  logic                                cap0_en_i,
  input  logic                                cap1_en_i,
  input  logic                                mode8_i,
  output logic [NUM_LINES-1:0][PAT_BITS-1:0]  pat_o
);
  localparam int unsigned HALF = NUM_LINES / 2;
  localparam int unsigned PAD  = PAT_BITS - 2;

  logic [NUM_LINES-1:0] first_q, second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      if (cap0_en_i) first_q  <= dat_i;
      if (cap1_en_i) second_q <= dat_i;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pat
    if (i < HALF) begin : g_low
      // lower half always takes part
      assign pat_o[i] = {~first_q[i], ~second_q[i], {PAD{1'b0}}};
    end else begin : g_high
      assign pat_o[i] = mode8_i ? {~first_q[i], ~second_q[i], {PAD{1'b0}}}
                                : '0;
    end
  end
endmodule

// File: rtl/bus_test_lane.sv
module bus_test_lane
  import bus_test_pkg::*;
#(
  parameter int unsigned          PAT_BITS = 8,
  parameter int unsigned          CRC_BITS = 16,
  parameter logic [CRC_BITS-1:0]  CRC_POLY = 16'h1021
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [PAT_BITS-1:0] pat_i,
  input  logic                step_i,
  input  phase_e              phase_i,
  output logic                bit_o
);
  logic [PAT_BITS-1:0] sh_q;
  logic [CRC_BITS-1:0] crc_q;
  logic                fb;

  assign fb = sh_q[PAT_BITS-1] ^ crc_q[CRC_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      crc_q <= '0;
    end else if (load_i) begin
      sh_q  <= pat_i;
      crc_q <= '0;
    end else if (step_i) begin
      if (phase_i == PH_DATA) begin
        sh_q  <= sh_q << 1;
        crc_q <= {crc_q[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end else begin
        crc_q <= crc_q << 1;
      end
    end
  end

  always_comb begin
    unique case (phase_i)
      PH_START: bit_o = 1'b0;
      PH_DATA:  bit_o = sh_q[PAT_BITS-1];
      PH_CRC:   bit_o = crc_q[CRC_BITS-1];
      default:  bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bus_test_seq.sv
module bus_test_seq
  import bus_test_pkg::*;
#(
  parameter int unsigned PAT_BITS = 8,
  parameter int unsigned CRC_BITS = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rx_start_i,
  input  logic   tx_start_i,
  input  logic   ref_line_i,
  input  logic   mode8_i,
  output logic   cap0_en_o,
  output logic   cap1_en_o,
  output logic   load_o,
  output logic   step_o,
  output phase_e phase_o,
  output logic   oe_o,
  output logic   mode8_o,
  output logic   rx_done_o,
  output logic   tx_done_o
);
  localparam int unsigned FRAME_LEN = PAT_BITS + CRC_BITS + 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam int unsigned CRC_FIRST = PAT_BITS + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode8_q, rx_done_q, tx_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      mode8_q   <= 1'b1;
      rx_done_q <= 1'b0;
      tx_done_q <= 1'b0;
    end else begin
      rx_done_q <= 1'b0;
      tx_done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rx_start_i) begin
            state_q <= ST_RX_WAIT;
            mode8_q <= mode8_i;
          end else if (tx_start_i) begin
            state_q <= ST_TX;
            cnt_q   <= '0;
          end
        end
        ST_RX_WAIT: if (!ref_line_i) state_q <= ST_RX_B0;
        ST_RX_B0:   state_q <= ST_RX_B1;
        ST_RX_B1: begin
          state_q   <= ST_IDLE;
          rx_done_q <= 1'b1;
        end
        ST_TX: begin
          if (cnt_q == LAST) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            tx_done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (cnt_q == '0)                       phase_o = PH_START;
    else if (cnt_q < CNT_W'(CRC_FIRST))    phase_o = PH_DATA;
    else if (cnt_q < LAST)                 phase_o = PH_CRC;
    else                                   phase_o = PH_END;
  end

  assign oe_o      = (state_q == ST_TX);
  assign load_o    = (state_q == ST_IDLE) && !rx_start_i && tx_start_i;
  assign step_o    = oe_o && (phase_o == PH_DATA || phase_o == PH_CRC);
  assign cap0_en_o = (state_q == ST_RX_B0);
  assign cap1_en_o = (state_q == ST_RX_B1);
  assign mode8_o   = mode8_q;
  assign rx_done_o = rx_done_q;
  assign tx_done_o = tx_done_q;
endmodule

// File: rtl/bus_test_responder.sv
module bus_test_responder
  import bus_test_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned PAT_BITS  = 8,
  parameter int unsigned CRC_BITS  = 16,
  parameter logic [15:0] CRC_POLY  = 16'h1021
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode8_i,
  input  logic                 rx_start_i,
  input  logic                 tx_start_i,
  input  logic [NUM_LINES-1:0] dat_i,
  output logic [NUM_LINES-1:0] dat_o,
  output logic [NUM_LINES-1:0] dat_oe_o,
  output logic                 rx_done_o,
  output logic                 tx_done_o
);
  logic                               cap0_en, cap1_en, load, step, oe, mode8_q;
  phase_e                             phase;
  logic [NUM_LINES-1:0][PAT_BITS-1:0] pat;
  logic [NUM_LINES-1:0]               lane_bit;

  bus_test_seq #(
    .PAT_BITS (PAT_BITS),
    .CRC_BITS (CRC_BITS)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_start_i (rx_start_i),
    .tx_start_i (tx_start_i),
    .ref_line_i (dat_i[0]),
    .mode8_i    (mode8_i),
    .cap0_en_o  (cap0_en),
    .cap1_en_o  (cap1_en),
    .load_o     (load),
    .step_o     (step),
    .phase_o    (phase),
    .oe_o       (oe),
    .mode8_o    (mode8_q),
    .rx_done_o  (rx_done_o),
    .tx_done_o  (tx_done_o)
  );

  bus_test_capture #(
    .NUM_LINES (NUM_LINES),
    .PAT_BITS  (PAT_BITS)
  ) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dat_i     (dat_i),
    .cap0_en_i (cap0_en),
    .cap1_en_i (cap1_en),
    .mode8_i   (mode8_q),
    .pat_o     (pat)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    bus_test_lane #(
      .PAT_BITS (PAT_BITS),
      .CRC_BITS (CRC_BITS),
      .CRC_POLY (CRC_POLY[CRC_BITS-1:0])
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .pat_i   (pat[i]),
      .step_i  (step),
      .phase_i (phase),
      .bit_o   (lane_bit[i])
    );
  end

  assign dat_oe_o = {NUM_LINES{oe}};
  assign dat_o    = oe ? lane_bit : '1;
endmodule

// File: rtl/bus_test_responder_chk.sv
module bus_test_responder_chk #(
  parameter int unsigned NUM_LINES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_start_i,
  input logic                 tx_start_i,
  input logic [NUM_LINES-1:0] dat_o,
  input logic [NUM_LINES-1:0] dat_oe_o,
  input logic                 rx_done_o,
  input logic                 tx_done_o
);
  a_r3_oe_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_oe_o == '0) || (dat_oe_o == '1));

  a_r3_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_oe_o[0]) |-> (dat_o == '0));

  a_r3_end_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dat_oe_o[0]) |-> ($past(dat_o) == '1));

  a_r7_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (dat_oe_o == '0) && ($past(dat_oe_o) == '1));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);

  a_r2_rx_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  a_r2_rx_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (dat_oe_o == '0));

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_oe_o[0] && $past(dat_oe_o[0]) && (tx_start_i || rx_start_i))
      |=> (dat_oe_o[0] || tx_done_o));
endmodule

bind bus_test_responder bus_test_responder_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_start_i (rx_start_i),
  .tx_start_i (tx_start_i),
  .dat_o      (dat_o),
  .dat_oe_o   (dat_oe_o),
  .rx_done_o  (rx_done_o),
  .tx_done_o  (tx_done_o)
);

// File: tb/bus_test_responder_tb_top.sv
`timescale 1ns/1ps
module bus_test_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode8 = 1'b1;
  logic       rx_start = 1'b0;
  logic       tx_start = 1'b0;
  logic [7:0] dat_in = 8'hFF;
  logic [7:0] dat_out, dat_oe;
  logic       rx_done, tx_done;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  bus_test_responder dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode8_i    (mode8),
    .rx_start_i (rx_start),
    .tx_start_i (tx_start),
    .dat_i      (dat_in),
    .dat_o      (dat_out),
    .dat_oe_o   (dat_oe),
    .rx_done_o  (rx_done),
    .tx_done_o  (tx_done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [7:0] p);
    logic [15:0] c = '0;
    for (int i = 7; i >= 0; i--) begin
      logic fb = p[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic frame_bit(input logic [7:0] p, input int k);
    logic [15:0] c = crc_of(p);
    if (k == 0) return 1'b0;
    if (k <= 8) return p[8-k];
    if (k <= 24) return c[24-k];
    return 1'b1;
  endfunction

  // expected pattern per line from the host bits (R4, R5)
  function automatic logic [7:0] exp_pat(input logic m8, input logic [7:0] b0,
                                         input logic [7:0] b1, input int i);
    if (!m8 && i >= 4) return 8'h00;
    return {~b0[i], ~b1[i], 6'b000000};
  endfunction

  task automatic host_send(input logic m8, input logic [7:0] b0, input logic [7:0] b1,
                           input logic decoy);
    @(negedge clk); rx_start = 1'b1; mode8 = m8;
    @(negedge clk); rx_start = 1'b0; dat_in = 8'hFF;
    @(negedge clk);
    if (decoy) begin
      // R2: lines other than line 0 going low must not start capture
      dat_in = 8'h01;
      @(negedge clk); dat_in = 8'hFF;
      @(negedge clk);
    end
    dat_in = m8 ? 8'h00 : 8'hF0;
    @(negedge clk); dat_in = b0;
    @(negedge clk); dat_in = b1;
    check("R2", "rx_done before capture", rx_done, 0);
    @(negedge clk); dat_in = 8'h3C;
    check("R2", "rx_done pulse", rx_done, 1);
    @(negedge clk); dat_in = 8'hC3;
    check("R2", "rx_done one cycle", rx_done, 0);
    // host CRC/don't-care bits, deliberately arbitrary
    for (int j = 0; j < 16; j++) begin
      @(negedge clk); dat_in = 8'(j * 37);
    end
    @(negedge clk); dat_in = 8'hFF;
    @(negedge clk);
  endtask

  task automatic card_reply(input string req, input logic [7:0] pats [8], input logic inject);
    logic [7:0] exp;
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    for (int k = 0; k < 26; k++) begin
      for (int i = 0; i < 8; i++) exp[i] = frame_bit(pats[i], k);
      check("R3", $sformatf("oe at frame bit %0d", k), dat_oe, 8'hFF);
      check(req, $sformatf("dat_o at frame bit %0d", k), dat_out, exp);
      tx_start = inject && (k == 10);
      rx_start = inject && (k == 10);
      @(negedge clk);
    end
    check("R7", "tx_done after end bit", tx_done, 1);
    check("R7", "oe released", dat_oe, 8'h00);
    @(negedge clk);
    check("R7", "tx_done one cycle", tx_done, 0);
    check("R8", "no restart after frame", dat_oe, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] p [8];
    check("R1", "oe after reset", dat_oe, 8'h00);
    check("R1", "rx_done after reset", rx_done, 0);
    check("R1", "tx_done after reset", tx_done, 0);
    for (int i = 0; i < 8; i++) p[i] = 8'hC0;
    card_reply("R1", p, 1'b0);
  endtask

  task automatic t_mode(input string req, input logic m8, input logic [7:0] b0,
                        input logic [7:0] b1, input logic decoy, input logic inject);
    logic [7:0] p [8];
    host_send(m8, b0, b1, decoy);
    for (int i = 0; i < 8; i++) p[i] = exp_pat(m8, b0, b1, i);
    card_reply(req, p, inject);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R4 R6: 8-line, alternating pattern
    t_mode("R4", 1'b1, 8'h55, 8'hAA, 1'b0, 1'b0);
    // R5: 4-line, upper lines idle high
    t_mode("R5", 1'b0, 8'hF5, 8'hFA, 1'b0, 1'b0);
    // R4: line 3 open (reads high), plus decoy on other lines for R2
    t_mode("R4", 1'b1, 8'h5D, 8'hAA, 1'b1, 1'b0);
    // R6: odd pattern bits per line for CRC variety
    t_mode("R6", 1'b1, 8'h0F, 8'h33, 1'b0, 1'b0);
    // R8: triggers pulsed mid-frame are ignored
    t_mode("R8", 1'b1, 8'h55, 8'hAA, 1'b0, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule